// File: doc/BRIEF.md
# Superscalar Issue Group Former

This block sits between an instruction fetch buffer and a set of parallel execution clusters. Each cycle it looks at a window of up to `SLOTS` fetched instructions, oldest in slot 0, and decides how many of them, counted from the oldest, can issue together. The only field it inspects is the destination of each instruction. The upper bits of the destination name the target cluster and the lower bits name a register inside that cluster. A separate pair flag asks for the instruction to be sent to two clusters at once: the named cluster and the one whose lowest index bit is flipped.

A group starts at slot 0 and grows only while each next instruction lands strictly above every cluster used by the instruction before it. An instruction that writes an equal or lower cluster, or an empty slot, closes the group. The remaining instructions wait for a later cycle. The result is registered. It comes out one cycle after the window is presented, as an issue count, a valid mask for each slot and a cluster steering mask for each slot. A consumed count tells the fetch buffer how far to shift.

Back-pressure uses a single `hold` pin. While `hold` is high the downstream clusters cannot accept a group. The block then reports zero issued and zero consumed on the following cycle, and the fetch buffer keeps its window unchanged. The window input carries no handshake of its own. A slot is offered when its valid bit is high, and it is taken only when it appears in the registered issue mask.

Top module: `issue_group_former`

## Requirements
- R1: While `rst_n` is low, `iss_count`, `consumed`, `iss_mask` and `iss_steer` are all zero, whatever the window holds.
- R2: Outputs follow the window with one cycle of latency. If `hold` is high at a rising edge, the outputs after that edge show count 0, mask 0 and steering 0.
- R3: When `hold` is low and slot 0 is valid, at least slot 0 issues. When slot 0 is not valid, the count is 0.
- R4: Slot k (k ≥ 1) joins the group only if slots 0..k-1 all joined and its cluster number is strictly greater than the previous slot's cluster number. An equal or lower cluster number closes the group.
- R5: A slot whose valid bit is low closes the group, even if later slots are valid and in increasing order.
- R6: An instruction whose pair flag is set occupies clusters c and c^1. The lowest cluster it occupies must exceed the highest cluster of the previous slot, and the next slot's cluster must exceed the highest of the pair.
- R7: `iss_mask` bit k is 1 exactly for slots k < `iss_count`. `consumed` always equals `iss_count`.
- R8: `iss_steer` bits [k*CLUSTERS +: CLUSTERS] hold slot k's cluster mask, with bit c set when the slot writes cluster c. The field is zero for slots that do not issue.
- R9: A build with `SLOTS` = 2 applies the same rule to slots 0 and 1 and never reports more than 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold | input | 1 | Downstream not ready; issue nothing this cycle |
| win_valid | input | SLOTS | Per-slot valid bit of the fetch window, slot 0 oldest |
| win_dest | input | SLOTS*(CL_W+REG_W) | Per-slot destination: cluster in the upper CL_W bits, register in the lower REG_W bits |
| win_pair | input | SLOTS | Per-slot flag that sends the instruction to a cluster pair |
| iss_count | output | $clog2(SLOTS+1) | Number of instructions issued from slot 0 upward |
| iss_mask | output | SLOTS | Per-slot issue valid |
| iss_steer | output | SLOTS*2**CL_W | Per-slot one-hot or pair cluster steering mask |
| consumed | output | $clog2(SLOTS+1) | Shift amount for the fetch buffer |

## Verification
Random cluster numbers rarely produce a long increasing run with pair flags in it. A full four-wide group, or a paired instruction between two neighbours that straddle the pair, is therefore hardest to bring about. The bench reaches these cases with directed windows: 0,1,2,3; a pair on cluster 1 followed by cluster 2; a pair on cluster 2 preceded by cluster 1. After that comes a long random run with a bias toward valid slots. The same window also feeds a two-wide build, so the two group widths are compared on identical cluster sequences.

// File: rtl/igf_pkg.sv
package igf_pkg;
  localparam int unsigned SLOTS_DEF = 4;
  localparam int unsigned CL_W_DEF  = 2;
  localparam int unsigned REG_W_DEF = 4;
endpackage

// File: rtl/igf_span.sv
module igf_span #(
  parameter int unsigned CL_W = igf_pkg::CL_W_DEF,
  localparam int unsigned NCL = 1 << CL_W
) (
  input  logic [CL_W-1:0] cl,
  input  logic            pair,
  output logic [CL_W-1:0] lo,
  output logic [CL_W-1:0] hi,
  output logic [NCL-1:0]  occ
);
  localparam logic [CL_W-1:0] LSB = CL_W'(1);
  localparam logic [NCL-1:0]  ONE = NCL'(1);

  always_comb begin
    if (pair) begin
      lo  = cl & ~LSB;
      hi  = cl | LSB;
      occ = (ONE << cl) | (ONE << (cl ^ LSB));
    end else begin
      lo  = cl;
      hi  = cl;
      occ = ONE << cl;
    end
  end
endmodule

// File: rtl/igf_chain.sv
module igf_chain #(
  parameter int unsigned SLOTS = igf_pkg::SLOTS_DEF,
  parameter int unsigned CL_W  = igf_pkg::CL_W_DEF,
  localparam int unsigned CNT_W = $clog2(SLOTS + 1)
) (
  input  logic [SLOTS-1:0]      valid,
  input  logic [SLOTS*CL_W-1:0] lo,
  input  logic [SLOTS*CL_W-1:0] hi,
  output logic [SLOTS-1:0]      take,
  output logic [CNT_W-1:0]      count
);
  assign take[0] = valid[0];

  genvar k;
  generate
    for (k = 1; k < SLOTS; k++) begin : g_link
      logic above;
      assign above   = lo[k*CL_W +: CL_W] > hi[(k-1)*CL_W +: CL_W];
      assign take[k] = take[k-1] & valid[k] & above;
    end
  endgenerate

  always_comb begin
    count = '0;
    for (int i = 0; i < SLOTS; i++) begin
      count = count + CNT_W'(take[i]);
    end
  end
endmodule

// File: rtl/issue_group_former.sv
module issue_group_former #(
  parameter int unsigned SLOTS = igf_pkg::SLOTS_DEF,
  parameter int unsigned CL_W  = igf_pkg::CL_W_DEF,
  parameter int unsigned REG_W = igf_pkg::REG_W_DEF,
  localparam int unsigned DW    = CL_W + REG_W,
  localparam int unsigned NCL   = 1 << CL_W,
  localparam int unsigned CNT_W = $clog2(SLOTS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 hold,
  input  logic [SLOTS-1:0]     win_valid,
  input  logic [SLOTS*DW-1:0]  win_dest,
  input  logic [SLOTS-1:0]     win_pair,
  output logic [CNT_W-1:0]     iss_count,
  output logic [SLOTS-1:0]     iss_mask,
  output logic [SLOTS*NCL-1:0] iss_steer,
  output logic [CNT_W-1:0]     consumed
);
  logic [SLOTS*CL_W-1:0] lo_all, hi_all;
  logic [SLOTS*NCL-1:0]  occ_all, steer_nx;
  logic [SLOTS-1:0]      take;
  logic [CNT_W-1:0]      count_nx;

  genvar k;
  generate
    for (k = 0; k < SLOTS; k++) begin : g_slot
      igf_span #(.CL_W(CL_W)) u_span (
        .cl   (win_dest[k*DW + REG_W +: CL_W]),
        .pair (win_pair[k]),
        .lo   (lo_all[k*CL_W +: CL_W]),
        .hi   (hi_all[k*CL_W +: CL_W]),
        .occ  (occ_all[k*NCL +: NCL])
      );
      assign steer_nx[k*NCL +: NCL] = take[k] ? occ_all[k*NCL +: NCL] : '0;
    end
  endgenerate

  igf_chain #(.SLOTS(SLOTS), .CL_W(CL_W)) u_chain (
    .valid (win_valid),
    .lo    (lo_all),
    .hi    (hi_all),
    .take  (take),
    .count (count_nx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iss_count <= '0;
      iss_mask  <= '0;
      iss_steer <= '0;
    end else if (hold) begin
      iss_count <= '0;
      iss_mask  <= '0;
      iss_steer <= '0;
    end else begin
      iss_count <= count_nx;
      iss_mask  <= take;
      iss_steer <= steer_nx;
    end
  end

  assign consumed = iss_count;

  assert_hold_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (iss_count == '0 && iss_steer == '0));

  assert_first_issues_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold && win_valid[0]) |=> iss_mask[0]);

  assert_mask_prefix_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (((iss_mask & (iss_mask + SLOTS'(1))) == '0) &&
     ($countones(iss_mask) == int'(iss_count))));

  generate
    for (k = 0; k < SLOTS; k++) begin : g_chk_slot
      assert_steer_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !iss_mask[k] |-> (iss_steer[k*NCL +: NCL] == '0));
    end
    for (k = 0; k < NCL; k++) begin : g_chk_cl
      logic [SLOTS-1:0] column;
      for (genvar s = 0; s < SLOTS; s++) begin : g_col
        assign column[s] = iss_steer[s*NCL + k];
      end
      assert_cluster_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(column));
    end
  endgenerate
endmodule

// File: tb/issue_group_former_bench.sv
module issue_group_former_bench;
  localparam int N = 4;
  localparam int DW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hold = 1'b0;
  logic [N-1:0] win_valid = '0;
  logic [N*DW-1:0] win_dest = '0;
  logic [N-1:0] win_pair = '0;
  logic [2:0] iss_count, consumed;
  logic [3:0] iss_mask;
  logic [15:0] iss_steer;
  logic [1:0] c2_count, c2_consumed;
  logic [1:0] c2_mask;
  logic [7:0] c2_steer;

  int n_cmp = 0;
  int n_bad = 0;
  bit draining_done = 1'b0;

  int     q_cnt[$];
  int     q_cnt2[$];
  logic [3:0]  q_mask[$];
  logic [15:0] q_steer[$];
  string  q_tag[$];

  always #4 clk = ~clk;

  issue_group_former u_issue_group_former (
    .clk(clk), .rst_n(rst_n), .hold(hold), .win_valid(win_valid),
    .win_dest(win_dest), .win_pair(win_pair), .iss_count(iss_count),
    .iss_mask(iss_mask), .iss_steer(iss_steer), .consumed(consumed));

  issue_group_former #(.SLOTS(2)) u_issue_group_former_w2 (
    .clk(clk), .rst_n(rst_n), .hold(hold), .win_valid(win_valid[1:0]),
    .win_dest(win_dest[2*DW-1:0]), .win_pair(win_pair[1:0]),
    .iss_count(c2_count), .iss_mask(c2_mask), .iss_steer(c2_steer),
    .consumed(c2_consumed));

  function automatic int ref_count(input logic [3:0] v, input logic [7:0] cl,
                                   input logic [3:0] pr, input int w);
    int n;
    int prev_hi, lo, hi;
    if (!v[0]) return 0;
    n = 1;
    prev_hi = pr[0] ? (int'(cl[1:0]) | 1) : int'(cl[1:0]);
    for (int k = 1; k < w; k++) begin
      lo = pr[k] ? (int'(cl[2*k +: 2]) & 2) : int'(cl[2*k +: 2]);
      hi = pr[k] ? (int'(cl[2*k +: 2]) | 1) : int'(cl[2*k +: 2]);
      if (!v[k] || lo <= prev_hi) break;
      n++;
      prev_hi = hi;
    end
    return n;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] v, input logic [7:0] cl, input logic [3:0] pr,
                       input logic h, input string tag);
    int n, n2;
    logic [3:0] m;
    logic [15:0] st;
    @(negedge clk);
    win_valid = v;
    win_pair  = pr;
    hold      = h;
    for (int k = 0; k < N; k++)
      win_dest[k*DW +: DW] = {cl[2*k +: 2], 4'($urandom_range(0, 15))};
    n  = h ? 0 : ref_count(v, cl, pr, 4);
    n2 = h ? 0 : ref_count(v, cl, pr, 2);
    m = '0;
    st = '0;
    for (int k = 0; k < n; k++) begin
      m[k] = 1'b1;
      st[k*4 + int'(cl[2*k +: 2])] = 1'b1;
      if (pr[k]) st[k*4 + (int'(cl[2*k +: 2]) ^ 1)] = 1'b1;
    end
    q_cnt.push_back(n);
    q_cnt2.push_back(n2);
    q_mask.push_back(m);
    q_steer.push_back(st);
    q_tag.push_back(tag);
  endtask

  always @(posedge clk) begin
    #2;
    if (rst_n && q_cnt.size() > 0) begin
      int e, e2;
      logic [3:0] em;
      logic [15:0] es;
      string t;
      e = q_cnt.pop_front();
      e2 = q_cnt2.pop_front();
      em = q_mask.pop_front();
      es = q_steer.pop_front();
      t = q_tag.pop_front();
      check({t, " count"}, int'(iss_count), e);
      check({"R7 consumed (", t, ")"}, int'(consumed), e);
      check({"R7 mask (", t, ")"}, int'(iss_mask), int'(em));
      check({"R8 steer (", t, ")"}, int'(iss_steer), int'(es));
      check({"R9 two-wide count (", t, ")"}, int'(c2_count), e2);
    end
  end

  initial begin
    #1_000_000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    win_valid = 4'hF;
    win_dest  = {6'h30, 6'h20, 6'h10, 6'h00};
    repeat (3) @(posedge clk);
    #2;
    check("R1 reset count", int'(iss_count), 0);
    check("R1 reset mask", int'(iss_mask), 0);
    check("R1 reset steer", int'(iss_steer), 0);
    check("R1 reset consumed", int'(consumed), 0);
    @(negedge clk);
    rst_n = 1'b1;

    // clusters listed slot3..slot0 as 2-bit fields
    drive(4'hF, {2'd3, 2'd2, 2'd1, 2'd0}, 4'h0, 1'b0, "R4 full rise");
    drive(4'hF, {2'd0, 2'd1, 2'd2, 2'd3}, 4'h0, 1'b0, "R4 falling");
    drive(4'hF, {2'd0, 2'd3, 2'd3, 2'd1}, 4'h0, 1'b0, "R4 equal ends");
    drive(4'hF, {2'd3, 2'd2, 2'd1, 2'd0}, 4'h0, 1'b1, "R2 hold");
    drive(4'hF, {2'd3, 2'd2, 2'd1, 2'd0}, 4'h0, 1'b0, "R2 after hold");
    drive(4'hE, {2'd3, 2'd2, 2'd1, 2'd0}, 4'h0, 1'b0, "R3 slot0 empty");
    drive(4'h1, {2'd0, 2'd0, 2'd0, 2'd3}, 4'h0, 1'b0, "R3 single");
    drive(4'hD, {2'd3, 2'd2, 2'd1, 2'd0}, 4'h0, 1'b0, "R5 gap slot1");
    drive(4'hB, {2'd3, 2'd2, 2'd1, 2'd0}, 4'h0, 1'b0, "R5 gap slot2");
    drive(4'hF, {2'd3, 2'd2, 2'd1, 2'd0}, 4'h1, 1'b0, "R6 pair0 then 1");
    drive(4'hF, {2'd0, 2'd3, 2'd2, 2'd1}, 4'h1, 1'b0, "R6 pair1 then 2");
    drive(4'hF, {2'd0, 2'd3, 2'd2, 2'd1}, 4'h2, 1'b0, "R6 1 then pair2");
    drive(4'hF, {2'd0, 2'd2, 2'd3, 2'd0}, 4'h2, 1'b0, "R6 0 then pair3");

    for (int i = 0; i < 3000; i++) begin
      logic [3:0] v, p;
      v = 4'($urandom) | 4'($urandom) | 4'($urandom);
      p = 4'($urandom) & 4'($urandom);
      drive(v, 8'($urandom), p, ($urandom_range(0, 15) == 0), "R4 random");
    end
    @(negedge clk);
    hold = 1'b0;
    win_valid = '0;
    repeat (3) @(posedge clk);
    #3;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule